// File: doc/BRIEF.md
# Bit-Serial Neuron Multiply-Accumulate Cell

This block is one neuron node of a digital neural-network array. It sits at the foot of a column of routing cells. A shared sequencer drives a set of single-cycle control strobes, and under them the node takes in serial streams from two diagonal buses: first two activations, then two weights. It multiplies each weight by its activation through one shift-and-add datapath and adds the products into a 16-bit accumulator. No standalone product is ever formed: the weight is held in an addend register, and that register is added or skipped according to each multiplier bit. The forward pair is handled first. On the last clock of that pass the backward weight is swapped into the addend, and a second pass handles the backward pair. After both passes a single carry-propagate clock settles the sum.

The accumulator keeps growing across every row of the column during one big cycle. Its upper byte is the argument sent out for the activation-function lookup. A new activation is loaded in parallel into a buffer and then shifted one bit per clock into the live activation register. Each incoming bit is compared with the bit it displaces, so the node can report whether its activation moved, which is the network's convergence test.

Top module: `neuron_mac_cell`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no strobe, `act_o`, `acc_o`, `arg_o`, `changed_o` and `act_ser_o` are all zero.
- R2: A clock with `act_load_i` high captures `act_par_i` into the activation buffer and clears `changed_o`. `act_o` does not change on that clock.
- R3: Each clock with `act_shift_i` high moves bit 0 of the buffer into bit 7 of `act_o`, shifts `act_o` right by one, and rotates the buffer right by one. After 8 such clocks `act_o` equals the loaded byte and the buffer again holds that byte.
- R4: On each `act_shift_i` clock, `changed_o` is set if the incoming bit differs from bit 0 of `act_o`. It stays set until the next `act_load_i`. After the 8th shift it is 1 exactly when the new byte differs from the previous `act_o`.
- R5: Each `opnd_shift_i` clock shifts `fbus_i` into bit 7 of the forward activation register and `bbus_i` into bit 7 of the backward activation register (8 clocks, least significant bit first). It also rotates `act_o` right by one, so `act_ser_o` (which always equals bit 0 of `act_o`) presents the activation least significant bit first, and `act_o` is restored after 8 clocks.
- R6: Each `wgt_shift_i` clock shifts `fbus_i` into the addend and `bbus_i` into the backward weight register (8 clocks, least significant bit first). Both weights are 8-bit two's complement; the addend holds the forward weight sign-extended to 16 bits.
- R7: Sixteen `mul_i` clocks followed by one `prop_i` clock add wf·af + wb·ab to `acc_o` modulo 2^16. Here the weights are signed, the activations are unsigned, and wf is the addend contents before the first `mul_i`. `prop_i` clears the addend, so a repeated multiply without new weights adds only wb·ab. `acc_o` is valid after `prop_i`, and no strobe other than `mul_i`, `prop_i` or `clr_i` changes it.
- R8: Products from successive rows accumulate without loss, wrapping modulo 2^16. A `clr_i` clock sets `acc_o` to zero and clears the addend.
- R9: `arg_o` equals bits 15:8 of `acc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start of big cycle: zero accumulator and addend |
| act_load_i | input | 1 | Load `act_par_i` into the activation buffer |
| act_par_i | input | 8 | New activation value |
| act_shift_i | input | 1 | Shift one buffer bit into the live activation |
| opnd_shift_i | input | 1 | Activation phase: shift serial activations in, rotate own activation out |
| wgt_shift_i | input | 1 | Weight phase: shift serial weights in |
| mul_i | input | 1 | One multiply clock |
| prop_i | input | 1 | Carry-propagate clock closing a row |
| fbus_i | input | 1 | Forward diagonal serial input |
| bbus_i | input | 1 | Backward diagonal serial input |
| act_ser_o | output | 1 | Own activation, serial, to the column |
| act_o | output | 8 | Live activation |
| changed_o | output | 1 | Activation differs from previous value |
| acc_o | output | 16 | Accumulator (valid after `prop_i`) |
| arg_o | output | 8 | Upper byte of accumulator, lookup argument |

## Verification
The assertions take for granted that the sequencer raises at most one strobe per clock. They also assume that multiply clocks come in runs of sixteen closed by one propagate clock, because a partial run leaves the carry-save state mid-sum. The stimulus issues strobes only through tasks that raise a single strobe for one clock. Every row is built as eight operand shifts, eight weight shifts, sixteen multiplies and one propagate. The bench also inserts idle clocks, reloads of an unchanged activation, and reruns of the multiply without fresh weights, and all of these stay inside that contract.

// File: rtl/neuron_mac_pkg.sv
package neuron_mac_pkg;

   // sign-extend an operand-width weight to the accumulator width
   function automatic logic [31:0] sext32(input logic [31:0] w, input int unsigned wbits);
      logic [31:0] r;
      r = w;
      for (int i = 0; i < 32; i++)
         if (i >= int'(wbits)) r[i] = w[wbits-1];
      return r;
   endfunction

endpackage

// File: rtl/nmc_act_stage.sv
module nmc_act_stage #(
   parameter int unsigned OPW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [OPW-1:0] par,
   input  logic           shift,
   input  logic           rot,
   output logic [OPW-1:0] cur,
   output logic           changed
);
   logic [OPW-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         cur     <= '0;
         changed <= 1'b0;
      end else if (load) begin
         buf_q   <= par;
         changed <= 1'b0;
      end else if (shift) begin
         buf_q <= {buf_q[0], buf_q[OPW-1:1]};
         cur   <= {buf_q[0], cur[OPW-1:1]};
         if (buf_q[0] != cur[0]) changed <= 1'b1;
      end else if (rot) begin
         cur <= {cur[0], cur[OPW-1:1]};
      end
   end
endmodule

// File: rtl/nmc_operand_regs.sv
module nmc_operand_regs #(
   parameter int unsigned OPW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           oshift,
   input  logic           wshift,
   input  logic           mul,
   input  logic           bwd_pass,
   input  logic           fbus,
   input  logic           bbus,
   output logic           mbit,
   output logic [OPW-1:0] bwt
);
   logic [OPW-1:0] fact_q, bact_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fact_q <= '0;
         bact_q <= '0;
         bwt    <= '0;
      end else begin
         if (oshift) begin
            fact_q <= {fbus, fact_q[OPW-1:1]};
            bact_q <= {bbus, bact_q[OPW-1:1]};
         end else if (mul && !bwd_pass) begin
            fact_q <= {fact_q[0], fact_q[OPW-1:1]};
         end else if (mul && bwd_pass) begin
            bact_q <= {bact_q[0], bact_q[OPW-1:1]};
         end
         if (wshift) bwt <= {bbus, bwt[OPW-1:1]};
      end
   end

   assign mbit = bwd_pass ? bact_q[0] : fact_q[0];
endmodule

// File: rtl/nmc_mac_core.sv
module nmc_mac_core
   import neuron_mac_pkg::*;
#(
   parameter int unsigned OPW    = 8,
   parameter int unsigned ACCW   = 16,
   parameter bit          CSA_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wshift,
   input  logic            fbus,
   input  logic            mul,
   input  logic            prop,
   input  logic            mbit,
   input  logic [OPW-1:0]  bwt,
   output logic            bwd_pass,
   output logic [ACCW-1:0] acc
);
   localparam int unsigned CW = $clog2(2 * OPW);
   localparam logic [CW-1:0] PASS1_LAST = CW'(OPW - 1);

   logic [CW-1:0]   mcnt_q;
   logic [ACCW-1:0] addend_q, term, bwt_ext;
   logic [31:0]     ext32;

   assign ext32    = sext32(32'(bwt), OPW);
   assign bwt_ext  = ext32[ACCW-1:0];
   assign bwd_pass = (mcnt_q > PASS1_LAST);
   assign term     = mbit ? addend_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt_q   <= '0;
         addend_q <= '0;
      end else if (clr || prop) begin
         mcnt_q   <= '0;
         addend_q <= '0;
      end else if (wshift) begin
         addend_q <= {{(ACCW-OPW){fbus}}, fbus, addend_q[OPW-1:1]};
      end else if (mul) begin
         mcnt_q   <= mcnt_q + 1'b1;
         addend_q <= (mcnt_q == PASS1_LAST) ? bwt_ext : (addend_q << 1);
      end
   end

   generate
      if (CSA_EN) begin : g_csa
         logic [ACCW-1:0] sum_q, car_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n || clr) begin
               sum_q <= '0;
               car_q <= '0;
            end else if (mul) begin
               sum_q <= sum_q ^ car_q ^ term;
               car_q <= ((sum_q & car_q) | (sum_q & term) | (car_q & term)) << 1;
            end else if (prop) begin
               sum_q <= sum_q + car_q;
               car_q <= '0;
            end
         end
         assign acc = sum_q;
      end else begin : g_ripple
         logic [ACCW-1:0] sum_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n || clr) sum_q <= '0;
            else if (mul)      sum_q <= sum_q + term;
         end
         assign acc = sum_q;
      end
   endgenerate
endmodule

// File: rtl/neuron_mac_cell.sv
module neuron_mac_cell #(
   parameter int unsigned OPW    = 8,
   parameter int unsigned ACCW   = 16,
   parameter bit          CSA_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            act_load_i,
   input  logic [OPW-1:0]  act_par_i,
   input  logic            act_shift_i,
   input  logic            opnd_shift_i,
   input  logic            wgt_shift_i,
   input  logic            mul_i,
   input  logic            prop_i,
   input  logic            fbus_i,
   input  logic            bbus_i,
   output logic            act_ser_o,
   output logic [OPW-1:0]  act_o,
   output logic            changed_o,
   output logic [ACCW-1:0] acc_o,
   output logic [OPW-1:0]  arg_o
);
   generate
      if (ACCW < 2 * OPW) begin : g_bad_width
         $error("accumulator must be at least twice the operand width");
      end
      if (OPW < 2 || ACCW > 32) begin : g_bad_range
         $error("operand width below 2 or accumulator above 32 bits");
      end
   endgenerate

   logic           mbit, bwd_pass;
   logic [OPW-1:0] bwt;

   nmc_act_stage #(.OPW(OPW)) u_act (
      .clk(clk), .rst_n(rst_n), .load(act_load_i), .par(act_par_i),
      .shift(act_shift_i), .rot(opnd_shift_i), .cur(act_o), .changed(changed_o)
   );

   nmc_operand_regs #(.OPW(OPW)) u_opnd (
      .clk(clk), .rst_n(rst_n), .oshift(opnd_shift_i), .wshift(wgt_shift_i),
      .mul(mul_i), .bwd_pass(bwd_pass), .fbus(fbus_i), .bbus(bbus_i),
      .mbit(mbit), .bwt(bwt)
   );

   nmc_mac_core #(.OPW(OPW), .ACCW(ACCW), .CSA_EN(CSA_EN)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(clr_i), .wshift(wgt_shift_i), .fbus(fbus_i),
      .mul(mul_i), .prop(prop_i), .mbit(mbit), .bwt(bwt),
      .bwd_pass(bwd_pass), .acc(acc_o)
   );

   assign act_ser_o = act_o[0];
   assign arg_o     = acc_o[ACCW-1:ACCW-OPW];
endmodule

// File: rtl/neuron_mac_cell_chk.sv
module neuron_mac_cell_chk #(
   parameter int unsigned OPW  = 8,
   parameter int unsigned ACCW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            clr_i,
   input logic            act_load_i,
   input logic            act_shift_i,
   input logic            opnd_shift_i,
   input logic            wgt_shift_i,
   input logic            mul_i,
   input logic            prop_i,
   input logic [OPW-1:0]  act_o,
   input logic            changed_o,
   input logic [ACCW-1:0] acc_o
);
   // operating contract: one strobe per clock
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clr_i, act_load_i, act_shift_i, opnd_shift_i, wgt_shift_i, mul_i, prop_i}));

   // R2
   load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_load_i |=> !changed_o);

   // R4
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(changed_o) |-> $past(act_load_i));

   // R3
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_shift_i || opnd_shift_i) |=> $stable(act_o));

   // R7
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mul_i || prop_i || clr_i) |=> $stable(acc_o));

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_o == '0));
endmodule

bind neuron_mac_cell neuron_mac_cell_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .act_load_i(act_load_i),
   .act_shift_i(act_shift_i), .opnd_shift_i(opnd_shift_i), .wgt_shift_i(wgt_shift_i),
   .mul_i(mul_i), .prop_i(prop_i), .act_o(act_o), .changed_o(changed_o), .acc_o(acc_o)
);

// File: tb/test_neuron_mac_cell.sv
`timescale 1ns/1ps
module test_neuron_mac_cell;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_i = 0, act_load_i = 0, act_shift_i = 0, opnd_shift_i = 0;
   logic wgt_shift_i = 0, mul_i = 0, prop_i = 0, fbus_i = 0, bbus_i = 0;
   logic [7:0]  act_par_i = '0;
   logic        act_ser_o, changed_o;
   logic [7:0]  act_o, arg_o;
   logic [15:0] acc_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   int m_cur, m_buf, m_chg, m_fa, m_ba, m_wf, m_wb, m_acc, m_muls;
   bit m_known;

   always #2.5 clk = ~clk;

   neuron_mac_cell i_neuron_mac_cell (.*);

   function automatic int s8(input int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cur = 0; m_buf = 0; m_chg = 0; m_fa = 0; m_ba = 0;
      m_wf = 0; m_wb = 0; m_acc = 0; m_muls = 0; m_known = 1;
   endtask

   task automatic model_step();
      int b;
      if (clr_i) begin m_acc = 0; m_wf = 0; m_muls = 0; m_known = 1; end
      if (act_load_i) begin m_buf = act_par_i; m_chg = 0; end
      if (act_shift_i) begin
         b = m_buf & 1;
         if (b != (m_cur & 1)) m_chg = 1;
         m_cur = (m_cur >> 1) | (b << 7);
         m_buf = (m_buf >> 1) | (b << 7);
      end
      if (opnd_shift_i) begin
         m_cur = (m_cur >> 1) | ((m_cur & 1) << 7);
         m_fa  = (m_fa >> 1) | (int'(fbus_i) << 7);
         m_ba  = (m_ba >> 1) | (int'(bbus_i) << 7);
      end
      if (wgt_shift_i) begin
         m_wf = (m_wf >> 1) | (int'(fbus_i) << 7);
         m_wb = (m_wb >> 1) | (int'(bbus_i) << 7);
      end
      if (mul_i) begin m_muls++; m_known = 0; end
      if (prop_i) begin
         if (m_muls == 16)
            m_acc = (m_acc + s8(m_wf) * m_fa + s8(m_wb) * m_ba) & 16'hFFFF;
         m_wf = 0; m_muls = 0; m_known = 1;
      end
   endtask

   task automatic compare_all();
      chk("R3 act_o", act_o, m_cur);
      chk("R4 changed_o", changed_o, m_chg);
      chk("R5 act_ser_o", act_ser_o, m_cur & 1);
      if (m_known) begin
         chk("R7 acc_o", acc_o, m_acc);
         chk("R9 arg_o", arg_o, m_acc >> 8);
      end
   endtask

   // one clock: inputs are already set; update model after edge, compare at negedge
   task automatic tick();
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
      compare_all();
      {clr_i, act_load_i, act_shift_i, opnd_shift_i, wgt_shift_i, mul_i, prop_i} = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic do_clr();
      clr_i = 1; tick();
      chk("R8 clear", acc_o, 0);
   endtask

   // R2 / R3 / R4
   task automatic new_act(input int v);
      act_par_i = 8'(v); act_load_i = 1; tick();
      chk("R2 flag cleared by load", changed_o, 0);
      for (int i = 0; i < 8; i++) begin act_shift_i = 1; tick(); end
   endtask

   // R5 activations, R6 weights, R7 multiply
   task automatic row(input int fa, input int ba, input int wf, input int wb);
      for (int i = 0; i < 8; i++) begin
         opnd_shift_i = 1; fbus_i = fa[i]; bbus_i = ba[i]; tick();
      end
      for (int i = 0; i < 8; i++) begin
         wgt_shift_i = 1; fbus_i = wf[i]; bbus_i = wb[i]; tick();
      end
      mult_only();
   endtask

   task automatic mult_only();
      for (int i = 0; i < 16; i++) begin mul_i = 1; tick(); end
      prop_i = 1; tick();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int exp_old;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      chk("R1 act_o", act_o, 0);
      chk("R1 acc_o", acc_o, 0);
      chk("R1 arg_o", arg_o, 0);
      chk("R1 changed_o", changed_o, 0);
      chk("R1 act_ser_o", act_ser_o, 0);
      rst_n = 1;
      idle(1);

      // R4: change from 0 to A5 flagged; same value reload not flagged
      new_act(8'hA5);
      chk("R4 changed after new value", changed_o, 1);
      new_act(8'hA5);
      chk("R4 unchanged after same value", changed_o, 0);
      chk("R3 act_o restored", act_o, 8'hA5);

      // R7 corner: extreme operands, R8 accumulation across rows
      do_clr();
      row(255, 255, 8'h80, 8'h7F);   // -128*255 + 127*255 = -255
      chk("R7 extreme row", acc_o, 16'hFF01);
      row(1, 0, 8'h05, 8'h00);       // +5
      chk("R8 accumulate", acc_o, 16'hFF06);
      row(0, 0, 8'hFF, 8'hFF);       // zero activations
      chk("R7 zero activations", acc_o, 16'hFF06);
      // R7: rerun without new weights adds backward product only
      row(3, 2, 8'h04, 8'hFD);       // 12 + (-6) = 6
      chk("R7 row", acc_o, 16'hFF0C);
      mult_only();                   // adds -6 only
      chk("R7 rerun backward only", acc_o, 16'hFF06);
      idle(4);

      // random big cycles
      for (int bc = 0; bc < 40; bc++) begin
         exp_old = m_cur;
         do_clr();
         new_act(int'($urandom_range(0, 255)));
         for (int r = 0; r < 6; r++)
            row(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
         if ((bc % 5) == 0) idle(3);
         chk("R4 flag vs previous", changed_o, (m_cur != exp_old) ? 1 : 0);
      end

      // R8 wrap: large positive products overflow modulo 2^16
      do_clr();
      for (int r = 0; r < 3; r++) row(255, 255, 8'h7F, 8'h7F);
      chk("R8 wrap", acc_o, (6 * 127 * 255) & 16'hFFFF);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule